// File: doc/BRIEF.md
# Event Timer with One Comparator Channel

This block is a free-running 64-bit event counter with one comparator channel, set up by software through a small register port. A write can be a whole 64-bit word or the low or high 32-bit half of a register. While the general run bit is set, the counter advances by one on every clock. The clock is meant to be slow enough, about 14.3 MHz or less, that the low 32 bits take more than four minutes to wrap. When the counter reaches the comparator value, the channel raises an interrupt. In one-shot mode the comparator stays where it is. In periodic mode the stored period is added to the comparator on each hit.

A narrow-mode bit in the timer configuration restricts matching and comparator arithmetic to the low 32 bits. A build parameter sets what that bit does to the main counter. In the blocking variant the upper counter half is held at zero and takes no carry. In the standard variant the counter stays a full 64 bits. Software programs periodic mode with a set-value sequence. The first comparator write, made while the set-value bit is set, loads both the comparator and the period. Later comparator writes change only the period.

Register select codes: 0 capabilities, 1 general configuration (bit 0 = run), 2 main counter, 3 timer configuration, 4 comparator. Timer configuration bits: 0 enable, 1 periodic, 2 set-value, 3 narrow mode, 4 level interrupt, 5 wide-capable (read-only, always 1), 6 match status (write 1 to clear).

Top module: `evt_timer`

## Requirements
- R1: After reset the counter, the general configuration and the timer configuration read 0, except bit 5 of the timer configuration, which reads 1. The comparator reads all ones and irq_o is low.
- R2: Capabilities bit 0 reads 1, meaning the counter is 64 bits wide. Capabilities bit 1 reads the BLOCK_CARRY build value. Timer configuration bit 5 always reads 1, whatever is written to it.
- R3: While the run bit is set, the counter advances by exactly one per clock, and counter writes have no effect. While the run bit is clear, the counter holds its value and accepts writes.
- R4: In one-shot mode with enable set, a clock in which the running counter equals the comparator sets status bit 6. The comparator is left unchanged.
- R5: In periodic mode, each match adds the period to the comparator.
- R6: A comparator write clears the set-value bit. In periodic mode, a comparator write made with the set-value bit set loads both the comparator and the period. A comparator write made without it loads only the period.
- R7: With narrow mode set, a match compares only the low 32 bits. Writes to the upper 32 bits of the comparator are ignored. The periodic addition wraps within the low 32 bits and leaves the upper half unchanged.
- R8: With BLOCK_CARRY=1 and narrow mode set, the upper counter half reads 0 and takes no carry. With BLOCK_CARRY=0, the counter carries across all 64 bits in narrow mode.
- R9: In level mode, irq_o stays high from the match until software writes 1 to status bit 6. In pulse mode, irq_o is high for exactly one clock per match.
- R10: A wide write updates all 64 bits in one clock. A narrow write, selected by hi, updates only that half. A narrow read returns the selected half in bits 31:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, which also drives the counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_addr | input | 3 | Register select |
| bus_wide | input | 1 | 1: 64-bit access, 0: 32-bit half access |
| bus_hi | input | 1 | Selects the half for a 32-bit access |
| bus_wdata | input | 64 | Write data (a half access uses bits 31:0) |
| bus_rdata | output | 64 | Combinational read data |
| irq_o | output | 1 | Comparator interrupt, level or pulse |

## Verification
A write becomes visible on the read port one clock after the edge that takes it. Reads are combinational, so the bench samples them just after a falling edge. A run started by a write at edge E0 advances the counter from E1 onward. A match is evaluated against the counter value held before each edge, so for a counter start X and a comparator C, the status bit and irq_o rise after edge C-X+1. The bench counts edges against these offsets and checks irq_o at each one. For the randomized runs it predicts the final counter, comparator and status by stepping through the same counter values the block evaluates.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
    localparam int REG_W  = 64;
    localparam int HALF_W = REG_W / 2;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CAPS = 3'd0,
        SEL_GCFG = 3'd1,
        SEL_CNT  = 3'd2,
        SEL_TCFG = 3'd3,
        SEL_CMP  = 3'd4
    } reg_sel_e;

    // timer configuration bit positions (software-visible)
    localparam int TB_EN   = 0;
    localparam int TB_PER  = 1;
    localparam int TB_SETV = 2;
    localparam int TB_NAR  = 3;
    localparam int TB_LVL  = 4;
    localparam int TB_CAP  = 5;
    localparam int TB_STS  = 6;

    typedef struct packed {
        logic en;
        logic per;
        logic setv;
        logic nar;
        logic lvl;
    } tcfg_t;

    // merge a write into an old register image (wide or one half)
    function automatic logic [REG_W-1:0] merge_half(input logic [REG_W-1:0] old_v,
                                                    input logic [REG_W-1:0] wd,
                                                    input logic wide,
                                                    input logic hi);
        if (wide)    return wd;
        else if (hi) return {wd[HALF_W-1:0], old_v[HALF_W-1:0]};
        else         return {old_v[REG_W-1:HALF_W], wd[HALF_W-1:0]};
    endfunction
endpackage

// File: rtl/evt_counter.sv
module evt_counter
    import evt_timer_pkg::*;
#(
    parameter bit BLOCK_CARRY = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             wr_i,
    input  logic             wide_i,
    input  logic             hi_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             narrow_i,
    output logic [REG_W-1:0] cnt_o
);
    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } cnt_t;

    cnt_t cnt_q, cnt_d;
    logic blk;

    assign blk = BLOCK_CARRY && narrow_i;

    always_comb begin
        cnt_d = cnt_q;
        if (run_i) begin
            cnt_d.lo = cnt_q.lo + 1'b1;
            if ((&cnt_q.lo) && !blk) cnt_d.hi = cnt_q.hi + 1'b1;
        end else if (wr_i) begin
            cnt_d = cnt_t'(merge_half(cnt_q, wdata_i, wide_i, hi_i));
        end
        if (blk) cnt_d.hi = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = blk ? {{HALF_W{1'b0}}, cnt_q.lo} : cnt_q;

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |=> cnt_q.lo == $past(cnt_q.lo) + 1'b1);
    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !wr_i && !blk) |=> $stable(cnt_q));
    // R8
    cnt_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk |=> cnt_q.hi == '0);
endmodule

// File: rtl/evt_channel.sv
module evt_channel
    import evt_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [REG_W-1:0] cnt_i,
    input  logic             cfg_wr_i,
    input  logic             cmp_wr_i,
    input  logic             wide_i,
    input  logic             hi_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] cfg_rd_o,
    output logic [REG_W-1:0] cmp_o,
    output logic             nar_o,
    output logic             irq_o
);
    typedef struct packed {
        tcfg_t            cfg;
        logic [REG_W-1:0] cmp;
        logic [REG_W-1:0] period;
        logic             sts;
        logic             pulse;
    } ch_t;

    ch_t ch_q, ch_d;
    logic lo_wr, match, clr;
    logic [REG_W-1:0] cmp_new, per_new;

    always_comb begin
        lo_wr = wide_i || !hi_i;
        match = ch_q.cfg.en && run_i &&
                (ch_q.cfg.nar ? (cnt_i[HALF_W-1:0] == ch_q.cmp[HALF_W-1:0])
                              : (cnt_i == ch_q.cmp));
        clr   = cfg_wr_i && lo_wr && wdata_i[TB_STS];

        cmp_new = merge_half(ch_q.cmp, wdata_i, wide_i, hi_i);
        per_new = merge_half(ch_q.period, wdata_i, wide_i, hi_i);
        if (ch_q.cfg.nar) begin
            cmp_new[REG_W-1:HALF_W] = ch_q.cmp[REG_W-1:HALF_W];
            per_new[REG_W-1:HALF_W] = ch_q.period[REG_W-1:HALF_W];
        end

        ch_d = ch_q;
        if (cfg_wr_i && lo_wr) begin
            ch_d.cfg.en   = wdata_i[TB_EN];
            ch_d.cfg.per  = wdata_i[TB_PER];
            ch_d.cfg.setv = wdata_i[TB_SETV];
            ch_d.cfg.nar  = wdata_i[TB_NAR];
            ch_d.cfg.lvl  = wdata_i[TB_LVL];
        end

        if (cmp_wr_i) begin
            ch_d.cfg.setv = 1'b0;
            if (!ch_q.cfg.per) begin
                ch_d.cmp = cmp_new;
            end else if (ch_q.cfg.setv) begin
                ch_d.cmp    = cmp_new;
                ch_d.period = per_new;
            end else begin
                ch_d.period = per_new;
            end
        end else if (match && ch_q.cfg.per) begin
            if (ch_q.cfg.nar)
                ch_d.cmp[HALF_W-1:0] = ch_q.cmp[HALF_W-1:0] + ch_q.period[HALF_W-1:0];
            else
                ch_d.cmp = ch_q.cmp + ch_q.period;
        end

        ch_d.sts   = (ch_q.sts && !clr) || match;
        ch_d.pulse = match;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q        <= '0;
            ch_q.cmp    <= '1;
        end else begin
            ch_q <= ch_d;
        end
    end

    always_comb begin
        cfg_rd_o         = '0;
        cfg_rd_o[TB_EN]  = ch_q.cfg.en;
        cfg_rd_o[TB_PER] = ch_q.cfg.per;
        cfg_rd_o[TB_SETV]= ch_q.cfg.setv;
        cfg_rd_o[TB_NAR] = ch_q.cfg.nar;
        cfg_rd_o[TB_LVL] = ch_q.cfg.lvl;
        cfg_rd_o[TB_CAP] = 1'b1;
        cfg_rd_o[TB_STS] = ch_q.sts;
    end

    assign cmp_o = ch_q.cmp;
    assign nar_o = ch_q.cfg.nar;
    assign irq_o = ch_q.cfg.lvl ? ch_q.sts : ch_q.pulse;

    // R4
    oneshot_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !ch_q.cfg.per && !cmp_wr_i) |=> $stable(ch_q.cmp));
    // R5
    periodic_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && ch_q.cfg.per && !ch_q.cfg.nar && !cmp_wr_i)
        |=> ch_q.cmp == $past(ch_q.cmp) + $past(ch_q.period));
    // R7
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ch_q.cfg.nar |=> ch_q.cmp[REG_W-1:HALF_W] == $past(ch_q.cmp[REG_W-1:HALF_W]));
    // R9
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_q.sts && !clr) |=> ch_q.sts);
    // R9
    pulse_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ch_q.pulse |-> ch_q.sts);
    // R6
    setv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr_i |=> !ch_q.cfg.setv);
endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter bit BLOCK_CARRY = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wide,
    input  logic              bus_hi,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq_o
);
    typedef struct packed {
        logic run;
    } top_t;

    top_t top_q, top_d;
    reg_sel_e sel;
    logic cnt_wr, cfg_wr, cmp_wr, nar;
    logic [REG_W-1:0] cnt, cfg_rd, cmp, full_rd;

    assign sel    = reg_sel_e'(bus_addr);
    assign cnt_wr = bus_wr_en && (sel == SEL_CNT) && !top_q.run;
    assign cfg_wr = bus_wr_en && (sel == SEL_TCFG);
    assign cmp_wr = bus_wr_en && (sel == SEL_CMP);

    always_comb begin
        top_d = top_q;
        if (bus_wr_en && (sel == SEL_GCFG) && (bus_wide || !bus_hi))
            top_d.run = bus_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    evt_counter #(.BLOCK_CARRY(BLOCK_CARRY)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (top_q.run),
        .wr_i     (cnt_wr),
        .wide_i   (bus_wide),
        .hi_i     (bus_hi),
        .wdata_i  (bus_wdata),
        .narrow_i (nar),
        .cnt_o    (cnt)
    );

    evt_channel u_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (top_q.run),
        .cnt_i    (cnt),
        .cfg_wr_i (cfg_wr),
        .cmp_wr_i (cmp_wr),
        .wide_i   (bus_wide),
        .hi_i     (bus_hi),
        .wdata_i  (bus_wdata),
        .cfg_rd_o (cfg_rd),
        .cmp_o    (cmp),
        .nar_o    (nar),
        .irq_o    (irq_o)
    );

    always_comb begin
        case (sel)
            SEL_CAPS: full_rd = {{(REG_W-2){1'b0}}, BLOCK_CARRY, 1'b1};
            SEL_GCFG: full_rd = {{(REG_W-1){1'b0}}, top_q.run};
            SEL_CNT:  full_rd = cnt;
            SEL_TCFG: full_rd = cfg_rd;
            SEL_CMP:  full_rd = cmp;
            default:  full_rd = '0;
        endcase
        if (bus_wide)    bus_rdata = full_rd;
        else if (bus_hi) bus_rdata = {{HALF_W{1'b0}}, full_rd[REG_W-1:HALF_W]};
        else             bus_rdata = {{HALF_W{1'b0}}, full_rd[HALF_W-1:0]};
    end

    // R3
    run_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (top_q.run && bus_wr_en && sel == SEL_CNT)
        |=> cnt[HALF_W-1:0] == $past(cnt[HALF_W-1:0]) + 1'b1);
endmodule

// File: tb/evt_timer_tb.sv
module evt_timer_tb;
    localparam int CLK_NS = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_NS/2) clk = ~clk;

    logic        wr_en = 1'b0;
    logic [2:0]  addr  = '0;
    logic        wide  = 1'b1;
    logic        hi    = 1'b0;
    logic [63:0] wdata = '0;
    logic [63:0] rd_a, rd_b;
    logic        irq_a, irq_b;

    evt_timer #(.BLOCK_CARRY(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(wr_en), .bus_addr(addr), .bus_wide(wide),
        .bus_hi(hi), .bus_wdata(wdata), .bus_rdata(rd_a), .irq_o(irq_a));
    evt_timer #(.BLOCK_CARRY(1'b0)) u_std (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(wr_en), .bus_addr(addr), .bus_wide(wide),
        .bus_hi(hi), .bus_wdata(wdata), .bus_rdata(rd_b), .irq_o(irq_b));

    int n_run = 0;
    int n_fail = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a falling edge; the write is taken at the next rising edge
    task automatic bwr(input logic [2:0] a, input logic [63:0] d,
                       input logic w = 1'b1, input logic h = 1'b0);
        addr = a; wdata = d; wide = w; hi = h; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic brd(input logic [2:0] a, output logic [63:0] va, output logic [63:0] vb,
                       input logic w = 1'b1, input logic h = 1'b0);
        addr = a; wide = w; hi = h;
        #1;
        va = rd_a; vb = rd_b;
    endtask

    function automatic logic [63:0] cfgw(input logic en, input logic per, input logic setv,
                                         input logic nar, input logic lvl, input logic clr);
        return {57'b0, clr, 1'b0, lvl, nar, setv, per, en};
    endfunction

    // run for exactly 'steps' counter increments, then halt
    task automatic run_steps(input int steps);
        bwr(3'd1, 64'd1);
        repeat (steps - 1) @(negedge clk);
        bwr(3'd1, 64'd0);
    endtask

    logic done = 1'b0;

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] va, vb;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        brd(3'd2, va, vb); chk("R1 cnt", va, 64'd0);
        brd(3'd1, va, vb); chk("R1 gcfg", va, 64'd0);
        brd(3'd3, va, vb); chk("R1 tcfg", va, 64'h20);
        brd(3'd4, va, vb); chk("R1 cmp", va, '1);
        chk("R1 irq", {63'b0, irq_a}, 64'd0);

        // R2 capabilities
        brd(3'd0, va, vb); chk("R2 caps blocking", va, 64'h3); chk("R2 caps std", vb, 64'h1);
        bwr(3'd3, 64'h0);
        brd(3'd3, va, vb); chk("R2 cap bit ro", va, 64'h20);

        // R3 write while running ignored
        bwr(3'd1, 64'd1);
        bwr(3'd2, 64'h1234);
        bwr(3'd1, 64'd0);
        brd(3'd2, va, vb); chk("R3 run write ignored", va, 64'd2);
        repeat (3) @(negedge clk);
        brd(3'd2, va, vb); chk("R3 halted holds", va, 64'd2);

        // R10 narrow and wide writes
        bwr(3'd2, 64'h89AB_CDEF, 1'b0, 1'b0);
        bwr(3'd2, 64'h0123_4567, 1'b0, 1'b1);
        brd(3'd2, va, vb); chk("R10 halves", va, 64'h0123_4567_89AB_CDEF);
        brd(3'd2, va, vb, 1'b0, 1'b1); chk("R10 narrow read hi", va, 64'h0123_4567);
        bwr(3'd2, 64'hFEDC_BA98_7654_3210);
        brd(3'd2, va, vb); chk("R10 wide", va, 64'hFEDC_BA98_7654_3210);

        // R9 level interrupt, R4 one-shot
        bwr(3'd3, cfgw(1, 0, 0, 0, 1, 0));
        bwr(3'd2, 64'd100);
        bwr(3'd4, 64'd105);
        bwr(3'd1, 64'd1);
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            chk($sformatf("R9 level k=%0d", k), {63'b0, irq_a}, {63'b0, k >= 6});
        end
        bwr(3'd1, 64'd0);
        chk("R9 level held", {63'b0, irq_a}, 64'd1);
        brd(3'd4, va, vb); chk("R4 cmp unchanged", va, 64'd105);
        brd(3'd3, va, vb); chk("R4 status", va, 64'h71);
        bwr(3'd3, cfgw(1, 0, 0, 0, 1, 1));
        chk("R9 w1c", {63'b0, irq_a}, 64'd0);

        // R9 pulse interrupt
        bwr(3'd3, cfgw(1, 0, 0, 0, 0, 0));
        bwr(3'd2, 64'd100);
        bwr(3'd1, 64'd1);
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            chk($sformatf("R9 pulse k=%0d", k), {63'b0, irq_a}, {63'b0, k == 6});
        end
        bwr(3'd1, 64'd0);
        bwr(3'd3, cfgw(0, 0, 0, 0, 0, 1));

        // R6 set-value sequence
        bwr(3'd3, cfgw(1, 1, 1, 0, 0, 0));
        bwr(3'd4, 64'd50);
        brd(3'd3, va, vb); chk("R6 setv cleared", va & 64'h4, 64'd0);
        bwr(3'd4, 64'd7);
        brd(3'd4, va, vb); chk("R6 period write keeps cmp", va, 64'd50);
        bwr(3'd2, 64'd48);
        run_steps(12);
        brd(3'd4, va, vb); chk("R5 R6 periodic cmp", va, 64'd64);
        bwr(3'd3, cfgw(0, 0, 0, 0, 0, 1));

        // R7 narrow compare, R8 variants
        bwr(3'd4, 64'd0);
        bwr(3'd3, cfgw(1, 0, 0, 1, 1, 0));
        bwr(3'd2, 64'h7_0000_0010);
        bwr(3'd4, 64'hABCD_0000_0014);
        brd(3'd4, va, vb); chk("R7 upper ignored", vb, 64'h14);
        run_steps(6);
        chk("R7 narrow match", {63'b0, irq_b}, 64'd1);
        brd(3'd2, va, vb);
        chk("R8 std keeps upper", vb, 64'h7_0000_0016);
        chk("R8 blocking upper zero", va, 64'h16);
        bwr(3'd3, cfgw(0, 0, 0, 1, 0, 1));
        bwr(3'd2, 64'h5_FFFF_FFFE);
        run_steps(3);
        brd(3'd2, va, vb);
        chk("R8 blocking no carry", va, 64'h1);
        chk("R8 std carry", vb, 64'h6_0000_0001);

        // constrained random runs
        for (int it = 0; it < 24; it++) begin
            logic per, nar, m;
            logic [63:0] x, c, p, cm, cs, cnt_s, cnt_b;
            int steps, hits;
            per = 1'($urandom);
            nar = 1'($urandom);
            x = {32'($urandom), 32'($urandom)};
            if (it % 4 == 0) x[31:0] = 32'hFFFF_FFF0;
            c = x + 64'($urandom_range(0, 30));
            p = 64'($urandom_range(1, 8));
            steps = $urandom_range(4, 40);
            brd(3'd4, va, vb); cm = va;
            bwr(3'd3, cfgw(1, per, per, nar, 1, 1));
            bwr(3'd2, x);
            bwr(3'd4, c);
            cm = nar ? {cm[63:32], c[31:0]} : c;
            if (per) bwr(3'd4, p);
            hits = 0;
            for (int k = 0; k < steps; k++) begin
                cs = x + 64'(k);
                m = nar ? (cs[31:0] == cm[31:0]) : (cs == cm);
                if (m) begin
                    hits++;
                    if (per) cm = nar ? {cm[63:32], cm[31:0] + p[31:0]} : cm + p;
                end
            end
            run_steps(steps);
            cnt_b = x + 64'(steps);
            cnt_s = nar ? {32'b0, cnt_b[31:0]} : cnt_b;
            brd(3'd2, va, vb);
            chk("R3 R8 rand cnt blocking", va, cnt_s);
            chk("R3 rand cnt std", vb, cnt_b);
            brd(3'd4, va, vb);
            chk("R4 R5 R7 rand cmp", va, cm);
            chk("R5 R7 rand cmp std", vb, cm);
            brd(3'd3, va, vb);
            chk("R4 rand status", va[6], hits > 0);
            chk("R9 rand irq", {63'b0, irq_b}, {63'b0, hits > 0});
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule